// File: doc/BRIEF.md
# Grouped Base/Conditional Channel Scheduler

This block decides the order in which the input-channel groups of a gated convolution layer are presented to a compute array. Input and output channels are split into the same number of groups G. Each output group computes a cheap partial sum from one input group, its base path. It may then go on to the remaining groups, its conditional path. Input group i is the base for output group i, so the base role moves from group to group across the layer instead of staying on one fixed group.

A start pulse latches the group count, given as its base-2 logarithm. The block then streams one token per (output group, input group) pair through a valid/ready handshake. Each token carries a flag that tells the base issue apart from the conditional ones. Two marker bits tag the end of each output group and the end of the layer. A one-cycle completion pulse follows the final token.

A separate combinational port gives the channel permutation the next layer uses when channel shuffling is turned on. It is the identity when shuffling is off.

Top module: `cgs_sched`

## Requirements
- R1: After reset, tok_valid_o and done_o are low.
- R2: The first token of each output group i has tok_in_grp_o equal to i and tok_base_o equal to 1.
- R3: After its base token, output group i issues conditional tokens (tok_base_o equal to 0) for input groups 0..i-1 and then i+1..G-1, in ascending order.
- R4: Output groups are issued in ascending order 0..G-1 with G tokens each, so the layer has G*G tokens and every input group appears as base exactly once.
- R5: tok_last_o is high exactly on the last token of each output group. tok_final_o is high only on the last token of the layer.
- R6: done_o is high for exactly one cycle, in the cycle after the final token is accepted, and tok_valid_o is low in that cycle.
- R7: While tok_valid_o is high and tok_ready_i is low, the token fields stay unchanged.
- R8: A start pulse that arrives while a sequence is running is ignored, and the running sequence and its group count are not changed.
- R9: grp_log2_i gives log2(G) and is latched on an accepted start. Values 1..4 select G = 2, 4, 8 and 16. A value of 0 is treated as 1, and values above 4 are treated as 4.
- R10: With shuf_en_i high, channel c = g*CPG + k (CPG = 4 channels per group) maps to map_ch_o = k*G + g, where G is the latched group count. With shuf_en_i low, map_ch_o equals map_ch_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a layer sequence when the block is idle |
| grp_log2_i | input | 3 | log2 of the group count, sampled on an accepted start |
| tok_valid_o | output | 1 | Token valid |
| tok_ready_i | input | 1 | Token accepted by the consumer |
| tok_out_grp_o | output | 4 | Output group of the token |
| tok_in_grp_o | output | 4 | Input group of the token |
| tok_base_o | output | 1 | 1 for a base-path token, 0 for a conditional-path token |
| tok_last_o | output | 1 | Last token of the current output group |
| tok_final_o | output | 1 | Last token of the layer |
| done_o | output | 1 | One-cycle pulse after the layer completes |
| shuf_en_i | input | 1 | Enables the shuffle permutation on the map port |
| map_ch_i | input | 6 | Output channel index to translate |
| map_ch_o | output | 6 | Next-layer channel index |

## Verification
A corrupted output-group or step counter shows up on the ports at the next token. The input group, base flag or marker bits fall out of the closed-form order at once, and a wrong wrap point shifts tok_last_o or makes the token count per layer wrong. A wrong latched group count shows in two places within one token or one map lookup: in the modulus of the token order and in the shuffle result. Running every group count, with and without backpressure, together with a full channel sweep of the map port, exposes each of these faults within one layer.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic {
    PATH_COND = 1'b0,
    PATH_BASE = 1'b1
  } path_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/cgs_seq.sv
module cgs_seq
  import cgs_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = 4,
  parameter int unsigned GW       = MAX_LOG2,
  parameter int unsigned LW       = $clog2(MAX_LOG2 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] grp_log2_i,
  input  logic          adv_i,
  output logic          run_o,
  output logic [GW-1:0] out_grp_o,
  output logic [GW-1:0] step_o,
  output logic [LW-1:0] glog_o,
  output logic          step_wrap_o,
  output logic          layer_end_o,
  output logic          done_o
);
  localparam logic [LW-1:0] LOG_MAX = LW'(MAX_LOG2);
  localparam logic [LW-1:0] LOG_MIN = LW'(1);

  seq_st_e       st_q;
  logic [GW-1:0] out_q, step_q, gmax;
  logic [LW-1:0] glog_q, glog_eff;
  logic [GW:0]   g_full;

  always_comb begin
    if (grp_log2_i == '0)          glog_eff = LOG_MIN;
    else if (grp_log2_i > LOG_MAX) glog_eff = LOG_MAX;
    else                           glog_eff = grp_log2_i;
  end

  assign g_full      = {{GW{1'b0}}, 1'b1} << glog_q;
  assign gmax        = GW'(g_full - 1'b1);
  assign step_wrap_o = (st_q == ST_RUN) && (step_q == gmax);
  assign layer_end_o = step_wrap_o && (out_q == gmax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      out_q  <= '0;
      step_q <= '0;
      glog_q <= LOG_MIN;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_RUN;
            out_q  <= '0;
            step_q <= '0;
            glog_q <= glog_eff;
          end
        end
        ST_RUN: begin
          if (adv_i) begin
            if (step_wrap_o) begin
              step_q <= '0;
              if (out_q == gmax) st_q  <= ST_DONE;
              else               out_q <= out_q + 1'b1;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (start_i) begin
            st_q   <= ST_RUN;
            out_q  <= '0;
            step_q <= '0;
            glog_q <= glog_eff;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o     = (st_q == ST_RUN);
  assign done_o    = (st_q == ST_DONE);
  assign out_grp_o = out_q;
  assign step_o    = step_q;
  assign glog_o    = glog_q;
endmodule

// File: rtl/cgs_order.sv
module cgs_order
  import cgs_pkg::*;
#(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] out_grp_i,
  input  logic [GW-1:0] step_i,
  output logic [GW-1:0] in_grp_o,
  output path_e         path_o
);
  logic [GW-1:0] cond_idx;

  // conditional slot m walks 0..G-2; skip over the base group
  assign cond_idx = step_i - 1'b1;

  always_comb begin
    if (step_i == '0) begin
      in_grp_o = out_grp_i;
      path_o   = PATH_BASE;
    end else begin
      in_grp_o = (cond_idx < out_grp_i) ? cond_idx : cond_idx + 1'b1;
      path_o   = PATH_COND;
    end
  end
endmodule

// File: rtl/cgs_shuffle.sv
module cgs_shuffle #(
  parameter int unsigned GW       = 4,
  parameter int unsigned CPG_LOG2 = 2,
  parameter int unsigned LW       = 3,
  parameter bit          HAS_SHUF = 1'b1,
  parameter int unsigned CW       = GW + CPG_LOG2
) (
  input  logic [CW-1:0] ch_i,
  input  logic [LW-1:0] glog_i,
  input  logic          en_i,
  output logic [CW-1:0] ch_o
);
  generate
    if (HAS_SHUF && CPG_LOG2 > 0) begin : g_shuf
      logic [GW-1:0]       grp;
      logic [CPG_LOG2-1:0] pos;
      logic [CW-1:0]       perm;
      assign grp  = ch_i[CW-1:CPG_LOG2];
      assign pos  = ch_i[CPG_LOG2-1:0];
      assign perm = (CW'(pos) << glog_i) | CW'(grp);
      assign ch_o = en_i ? perm : ch_i;
    end else begin : g_ident
      logic unused_sig;
      assign unused_sig = ^{glog_i, en_i};
      assign ch_o       = ch_i;
    end
  endgenerate
endmodule

// File: rtl/cgs_sched.sv
module cgs_sched
  import cgs_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = 4,
  parameter int unsigned CPG_LOG2 = 2,
  parameter bit          HAS_SHUF = 1'b1,
  parameter int unsigned GW       = MAX_LOG2,
  parameter int unsigned LW       = $clog2(MAX_LOG2 + 1),
  parameter int unsigned CW       = GW + CPG_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] grp_log2_i,
  output logic          tok_valid_o,
  input  logic          tok_ready_i,
  output logic [GW-1:0] tok_out_grp_o,
  output logic [GW-1:0] tok_in_grp_o,
  output logic          tok_base_o,
  output logic          tok_last_o,
  output logic          tok_final_o,
  output logic          done_o,
  input  logic          shuf_en_i,
  input  logic [CW-1:0] map_ch_i,
  output logic [CW-1:0] map_ch_o
);
  logic          run, step_wrap, layer_end, adv;
  logic [GW-1:0] out_grp, step;
  logic [LW-1:0] glog;
  path_e         path;

  assign adv = run && tok_ready_i;

  cgs_seq #(
    .MAX_LOG2(MAX_LOG2), .GW(GW), .LW(LW)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .grp_log2_i  (grp_log2_i),
    .adv_i       (adv),
    .run_o       (run),
    .out_grp_o   (out_grp),
    .step_o      (step),
    .glog_o      (glog),
    .step_wrap_o (step_wrap),
    .layer_end_o (layer_end),
    .done_o      (done_o)
  );

  cgs_order #(.GW(GW)) u_order (
    .out_grp_i (out_grp),
    .step_i    (step),
    .in_grp_o  (tok_in_grp_o),
    .path_o    (path)
  );

  cgs_shuffle #(
    .GW(GW), .CPG_LOG2(CPG_LOG2), .LW(LW), .HAS_SHUF(HAS_SHUF), .CW(CW)
  ) u_shuf (
    .ch_i   (map_ch_i),
    .glog_i (glog),
    .en_i   (shuf_en_i),
    .ch_o   (map_ch_o)
  );

  assign tok_valid_o   = run;
  assign tok_out_grp_o = out_grp;
  assign tok_base_o    = (path == PATH_BASE);
  assign tok_last_o    = step_wrap;
  assign tok_final_o   = layer_end;
endmodule

// File: rtl/cgs_sched_chk.sv
module cgs_sched_chk #(
  parameter int unsigned GW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tok_valid_o,
  input logic          tok_ready_i,
  input logic [GW-1:0] tok_out_grp_o,
  input logic [GW-1:0] tok_in_grp_o,
  input logic          tok_base_o,
  input logic          tok_last_o,
  input logic          tok_final_o,
  input logic          done_o
);
  a_r2_base_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_base_o) |-> (tok_in_grp_o == tok_out_grp_o));

  a_r3_cond_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && !tok_base_o) |-> (tok_in_grp_o != tok_out_grp_o));

  a_r5_final_is_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_final_o |-> (tok_valid_o && tok_last_o));

  a_r6_done_after_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_ready_i && tok_final_o) |=> done_o);

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tok_valid_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && !tok_ready_i) |=>
      (tok_valid_o && $stable(tok_out_grp_o) && $stable(tok_in_grp_o)
       && $stable(tok_base_o) && $stable(tok_last_o)));
endmodule

bind cgs_sched cgs_sched_chk #(.GW(GW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tok_valid_o   (tok_valid_o),
  .tok_ready_i   (tok_ready_i),
  .tok_out_grp_o (tok_out_grp_o),
  .tok_in_grp_o  (tok_in_grp_o),
  .tok_base_o    (tok_base_o),
  .tok_last_o    (tok_last_o),
  .tok_final_o   (tok_final_o),
  .done_o        (done_o)
);

// File: tb/cgs_sched_bench.sv
module cgs_sched_bench;
  localparam int CPG = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] grp = '0;
  logic       ready = 1'b0;
  logic       shuf_en = 1'b0;
  logic [5:0] map_in = '0;
  logic       tv, tbase, tlast, tfinal, done;
  logic [3:0] tout, tin;
  logic [5:0] map_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cgs_sched u_cgs_sched (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .grp_log2_i(grp),
    .tok_valid_o(tv), .tok_ready_i(ready), .tok_out_grp_o(tout),
    .tok_in_grp_o(tin), .tok_base_o(tbase), .tok_last_o(tlast),
    .tok_final_o(tfinal), .done_o(done), .shuf_en_i(shuf_en),
    .map_ch_i(map_in), .map_ch_o(map_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_layer(input int req, input int lg, input int mode, input bit inject);
    int g = 1 << lg;
    int n = 0;
    int cyc = 0;
    bit held = 0;
    int h_out = 0, h_in = 0, h_base = 0;
    int base_cnt[16];
    for (int q = 0; q < 16; q++) base_cnt[q] = 0;
    @(negedge clk);
    grp = 3'(req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    grp = 3'(req + 3);
    while (n < g * g) begin
      bit rdy = (mode == 0) || ((cyc % 3) != 1);
      cyc++;
      start = inject && (n == 3);
      if (held) begin
        chk(tv && int'(tout) == h_out && int'(tin) == h_in && int'(tbase) == h_base,
            "R7 stall hold", int'(tin), h_in);
        held = 0;
      end
      if (tv) begin
        if (rdy) begin
          int i = n / g;
          int j = n % g;
          int e_in = (j == 0) ? i : (((j - 1) < i) ? (j - 1) : j);
          chk(int'(tout) == i, "R4 out group order", int'(tout), i);
          if (j == 0) begin
            chk(int'(tin) == i && tbase, "R2 base first", int'(tin), i);
            base_cnt[tin]++;
          end else begin
            chk(int'(tin) == e_in && !tbase, "R3 conditional order", int'(tin), e_in);
          end
          chk(tlast == (j == g - 1), "R5 last marker", int'(tlast), int'(j == g - 1));
          chk(tfinal == (n == g * g - 1), "R5 final marker", int'(tfinal), int'(n == g * g - 1));
          n++;
        end else begin
          h_out = int'(tout); h_in = int'(tin); h_base = int'(tbase);
          held = 1;
        end
      end else begin
        chk(1'b0, "R4 valid gap", 0, 1);
      end
      ready = rdy;
      @(negedge clk);
    end
    ready = 1'b0;
    start = 1'b0;
    chk(done && !tv, "R6 done after final", int'(done), 1);
    for (int q = 0; q < g; q++)
      chk(base_cnt[q] == 1, "R4 base once", base_cnt[q], 1);
    if (inject) chk(n == g * g, "R8 start ignored", n, g * g);
    @(negedge clk);
    chk(!done && !tv, "R6 done one cycle", int'(done), 0);
    // map port sweep with the latched group count
    for (int c = 0; c < g * CPG; c++) begin
      int e = (c % CPG) * g + (c / CPG);
      map_in = 6'(c);
      shuf_en = 1'b1;
      #0.5;
      chk(int'(map_out) == e, (req == lg) ? "R10 shuffle map" : "R9 clamp via map",
          int'(map_out), e);
      shuf_en = 1'b0;
      #0.5;
      chk(int'(map_out) == c, "R10 identity map", int'(map_out), c);
    end
  endtask

  initial begin
    #1;
    chk(!tv && !done, "R1 reset idle", int'(tv), 0);
    #9;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tv && !done, "R1 idle after reset", int'(tv), 0);
    run_layer(1, 1, 0, 1'b0);
    run_layer(2, 2, 1, 1'b1);
    run_layer(3, 3, 0, 1'b1);
    run_layer(4, 4, 1, 1'b1);
    run_layer(0, 1, 1, 1'b0);
    run_layer(6, 4, 0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule